// File: doc/BRIEF.md
# Banked Working-Register RAM

This block is the 128-byte internal data store of a small 8-bit core. It has two ways in. The register path names one of eight working registers by a 3-bit index. The direct path names any byte by address. The register path is a moving window onto the lowest 32 bytes. Two bank bits held in the block pick which group of eight consecutive bytes the indices refer to. The register byte is found at bank × 8 + index.

Both paths reach the same storage. A byte written by register name and read back by address, or the other way round, gives the same value. Bytes 20h–7Fh are reached only through the direct path. The bank bits are loaded through a strobe and return to bank 0 on reset. A direct address whose top bit is set lies outside the store. Such an access is refused and reported on an error output.

Top module: `banked_regram`

## Requirements
- R1: After reset, `rd_data` is 00h, `addr_err` is 0 and bank 0 is active, so register index n maps to address n.
- R2: A register access with bank b and index i targets RAM address b*8+i (bank in address bits 4:3, index in bits 2:0). This covers all 32 bytes 00h–1Fh.
- R3: A byte written through one path reads back the same value through the other path.
- R4: Every direct address from 20h to 7Fh stores a written byte and returns it on a later direct read.
- R5: Read data appears on `rd_data` on the clock edge that samples the read strobe. It then holds until the next read.
- R6: A direct access with `dir_addr[7]`=1 raises `addr_err` for the following cycle. A refused write changes no byte. A refused read returns 00h.
- R7: A `bank_load` sampled on one edge changes the bank for register accesses on later edges. A register access on that same edge still uses the previous bank.
- R8: When a register access and a direct access are requested in the same cycle, only the register access is performed.
- R9: A read and a write to the same target in the same cycle return the byte's previous contents, and the new value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_load | input | 1 | Strobe that loads `bank_next` into the bank bits |
| bank_next | input | 2 | New bank value |
| reg_rd | input | 1 | Register read request |
| reg_wr | input | 1 | Register write request |
| reg_idx | input | 3 | Working-register index 0–7 |
| dir_rd | input | 1 | Direct read request |
| dir_wr | input | 1 | Direct write request |
| dir_addr | input | 8 | Direct byte address; bit 7 set is out of range |
| wr_data | input | 8 | Write data for either path |
| rd_data | output | 8 | Registered read data |
| addr_err | output | 1 | One-cycle flag for a refused direct access |

## Verification
A wrong bank value or a wrong address mapping is not visible at once. It shows up when a byte written by register name is read back through the direct path at an unexpected address, which is one write and one read later. For that reason, every bank and index pair is written and then checked directly across all 32 low bytes. A dropped or misplaced write shows as wrong `rd_data` on the cycle after the next read of that byte. A wrong error decision shows on `addr_err` one cycle after the access.

// File: rtl/banked_regram_pkg.sv
package banked_regram_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 3;
  localparam int BANK_W = 2;
  localparam int DIR_W  = 8;
  localparam int ADDR_W = DIR_W - 1;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  function automatic addr_t reg_to_addr(input logic [BANK_W-1:0] bank,
                                        input logic [IDX_W-1:0] idx);
    return addr_t'({bank, idx});
  endfunction
endpackage

// File: rtl/banked_regram_bank.sv
module banked_regram_bank
  import banked_regram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BANK_W-1:0] next_val,
  output logic [BANK_W-1:0] bank
);
  logic [BANK_W-1:0] bank_d;

  always_comb begin
    bank_d = bank;
    if (load) bank_d = next_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank <= '0;
    else        bank <= bank_d;
  end
endmodule

// File: rtl/banked_regram_amap.sv
module banked_regram_amap
  import banked_regram_pkg::*;
(
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [BANK_W-1:0] bank,
  input  logic              dir_rd,
  input  logic              dir_wr,
  input  logic [DIR_W-1:0]  dir_addr,
  output addr_t             addr,
  output logic              re,
  output logic              we,
  output logic              blank
);
  logic reg_acc;
  assign reg_acc = reg_rd | reg_wr;

  always_comb begin
    if (reg_acc) begin
      addr  = reg_to_addr(bank, reg_idx);
      re    = reg_rd;
      we    = reg_wr;
      blank = 1'b0;
    end else begin
      addr  = dir_addr[ADDR_W-1:0];
      blank = dir_addr[DIR_W-1] & (dir_rd | dir_wr);
      re    = dir_rd;
      we    = dir_wr & ~dir_addr[DIR_W-1];
    end
  end
endmodule

// File: rtl/banked_regram_store.sv
module banked_regram_store
  import banked_regram_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  addr_t addr,
  input  logic  re,
  input  logic  we,
  input  logic  blank,
  input  byte_t wdata,
  output byte_t rdata
);
  byte_t mem [DEPTH];
  byte_t rdata_d;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_comb begin
    rdata_d = rdata;
    if (re) rdata_d = blank ? '0 : mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end
endmodule

// File: rtl/banked_regram.sv
module banked_regram
  import banked_regram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_load,
  input  logic [BANK_W-1:0] bank_next,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic              dir_rd,
  input  logic              dir_wr,
  input  logic [DIR_W-1:0]  dir_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              addr_err
);
  logic [1:0]        rst_pipe;
  logic              rst_s_n;
  logic [BANK_W-1:0] bank_cur;
  addr_t             ram_addr;
  logic              ram_re, ram_we, ram_blank;
  logic              err_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  banked_regram_bank u_bank (
    .clk(clk), .rst_n(rst_s_n), .load(bank_load),
    .next_val(bank_next), .bank(bank_cur)
  );

  banked_regram_amap u_amap (
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_idx(reg_idx), .bank(bank_cur),
    .dir_rd(dir_rd), .dir_wr(dir_wr), .dir_addr(dir_addr),
    .addr(ram_addr), .re(ram_re), .we(ram_we), .blank(ram_blank)
  );

  banked_regram_store u_store (
    .clk(clk), .rst_n(rst_s_n), .addr(ram_addr), .re(ram_re),
    .we(ram_we), .blank(ram_blank), .wdata(wr_data), .rdata(rd_data)
  );

  assign err_d = ram_blank;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) addr_err <= 1'b0;
    else          addr_err <= err_d;
  end
endmodule

// File: rtl/banked_regram_chk.sv
module banked_regram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bank_load,
  input logic       reg_rd,
  input logic       reg_wr,
  input logic       dir_rd,
  input logic       dir_wr,
  input logic [7:0] dir_addr,
  input logic [1:0] bank_cur,
  input logic [7:0] rd_data,
  input logic       addr_err
);
  logic reg_acc, bad_dir;
  assign reg_acc = reg_rd | reg_wr;
  assign bad_dir = !reg_acc && (dir_rd || dir_wr) && dir_addr[7];

  // R6
  refused_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_dir |=> addr_err);

  // R6
  no_spurious_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_dir |=> !addr_err);

  // R6
  refused_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_dir && dir_rd) |=> rd_data == 8'h00);

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd || dir_rd) |=> $stable(rd_data));

  // R7
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_load |=> $stable(bank_cur));
endmodule

bind banked_regram banked_regram_chk u_chk (
  .clk(clk), .rst_n(rst_s_n), .bank_load(bank_load), .reg_rd(reg_rd),
  .reg_wr(reg_wr), .dir_rd(dir_rd), .dir_wr(dir_wr), .dir_addr(dir_addr),
  .bank_cur(bank_cur), .rd_data(rd_data), .addr_err(addr_err)
);

// File: tb/banked_regram_tb.sv
module banked_regram_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bank_load;
  logic [1:0] bank_next;
  logic       reg_rd, reg_wr;
  logic [2:0] reg_idx;
  logic       dir_rd, dir_wr;
  logic [7:0] dir_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       addr_err;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  banked_regram u_dut (
    .clk(clk), .rst_n(rst_n), .bank_load(bank_load), .bank_next(bank_next),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_idx(reg_idx), .dir_rd(dir_rd),
    .dir_wr(dir_wr), .dir_addr(dir_addr), .wr_data(wr_data),
    .rd_data(rd_data), .addr_err(addr_err)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    bank_load = 0; bank_next = 0; reg_rd = 0; reg_wr = 0; reg_idx = 0;
    dir_rd = 0; dir_wr = 0; dir_addr = 0; wr_data = 0;
  endtask

  // each op: drive at a falling edge, one rising edge, then idle at next falling edge
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic set_bank(input logic [1:0] b);
    @(negedge clk); bank_load = 1; bank_next = b; step();
  endtask

  task automatic reg_write(input logic [2:0] i, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_idx = i; wr_data = d; step();
  endtask

  task automatic dir_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); dir_wr = 1; dir_addr = a; wr_data = d; step();
  endtask

  task automatic reg_read(input logic [2:0] i, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_idx = i; step(); d = rd_data;
  endtask

  task automatic dir_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); dir_rd = 1; dir_addr = a; step(); d = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 addr_err", {7'b0, addr_err}, 8'h00);
    reg_write(3'd5, 8'h5C);
    dir_read(8'h05, d);
    check("R1 bank0 index5", d, 8'h5C);
  endtask

  task automatic t_map();
    logic [7:0] d;
    for (int b = 0; b < 4; b++) begin
      set_bank(b[1:0]);
      for (int i = 0; i < 8; i++) reg_write(i[2:0], 8'(b * 8 + i) ^ 8'hA5);
    end
    for (int a = 0; a < 32; a++) begin
      dir_read(8'(a), d);
      check("R2 bank*8+idx", d, 8'(a) ^ 8'hA5);
    end
  endtask

  task automatic t_alias();
    logic [7:0] d;
    dir_write(8'h13, 8'h3E);
    set_bank(2'd2);
    reg_read(3'd3, d);
    check("R3 direct->reg", d, 8'h3E);
    reg_write(3'd6, 8'hC1);
    dir_read(8'h16, d);
    check("R3 reg->direct", d, 8'hC1);
  endtask

  task automatic t_scratch();
    logic [7:0] d;
    logic [7:0] addrs [5] = '{8'h20, 8'h2F, 8'h30, 8'h55, 8'h7F};
    foreach (addrs[k]) dir_write(addrs[k], 8'h11 + 8'(k * 17));
    foreach (addrs[k]) begin
      dir_read(addrs[k], d);
      check("R4 upper byte", d, 8'h11 + 8'(k * 17));
    end
  endtask

  task automatic t_hold();
    logic [7:0] d;
    dir_read(8'h20, d);
    repeat (3) @(negedge clk);
    check("R5 held", rd_data, 8'h11);
    dir_write(8'h21, 8'h99);
    check("R5 held over write", rd_data, 8'h11);
  endtask

  task automatic t_err();
    logic [7:0] d;
    dir_write(8'h05, 8'h42);
    @(negedge clk); dir_wr = 1; dir_addr = 8'h85; wr_data = 8'h77; step();
    check("R6 flag", {7'b0, addr_err}, 8'h01);
    @(negedge clk);
    check("R6 flag clears", {7'b0, addr_err}, 8'h00);
    dir_read(8'h05, d);
    check("R6 write dropped", d, 8'h42);
    dir_read(8'h90, d);
    check("R6 read zero", d, 8'h00);
    check("R6 read flag", {7'b0, addr_err}, 8'h01);
  endtask

  task automatic t_bank_timing();
    logic [7:0] d;
    set_bank(2'd0);
    @(negedge clk); bank_load = 1; bank_next = 2'd3;
    reg_wr = 1; reg_idx = 3'd0; wr_data = 8'hD0; step();
    reg_write(3'd0, 8'hD3);
    dir_read(8'h00, d);
    check("R7 same-edge old bank", d, 8'hD0);
    dir_read(8'h18, d);
    check("R7 next access new bank", d, 8'hD3);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    set_bank(2'd0);
    dir_write(8'h40, 8'h0F);
    @(negedge clk); reg_wr = 1; reg_idx = 3'd1; dir_wr = 1; dir_addr = 8'h40;
    wr_data = 8'hAB; step();
    dir_read(8'h01, d);
    check("R8 reg write done", d, 8'hAB);
    dir_read(8'h40, d);
    check("R8 direct write dropped", d, 8'h0F);
  endtask

  task automatic t_rdw();
    logic [7:0] d;
    reg_write(3'd2, 8'h61);
    @(negedge clk); reg_rd = 1; reg_wr = 1; reg_idx = 3'd2; wr_data = 8'h62; step();
    check("R9 old value", rd_data, 8'h61);
    reg_read(3'd2, d);
    check("R9 new stored", d, 8'h62);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_map();
    t_alias();
    t_scratch();
    t_hold();
    t_err();
    t_bank_timing();
    t_priority();
    t_rdw();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule